// File: doc/BRIEF.md
# Burst-Envelope Blanking Estimator with Gain-Error Pump Drive

This block sits after the digitizer of a video front end whose samples are already clamped so that the sync tip lands on a fixed low code. On every line a gate covers the colour burst. While that gate is open, two running registers keep the largest and the smallest sample seen. The blanking level is then taken as the midpoint of those two values. No lowpass filter is used: the burst is a sine wave, so its peak and trough bracket the pedestal it rides on.

When the next sync pulse begins, the block measures the sync height as the blanking estimate minus the clamp tip code. It subtracts that height from a programmed target to get a signed error, and latches the error. While that sync pulse lasts, it asserts either a raise or a lower enable for an external charge pump. Neither enable is asserted when the error falls inside a configurable dead-band. A per-line clear signal restores the two envelope registers before the gate opens.

Top module: `burst_agc_err`

## Requirements
- R1: While `rst` is high at a clock edge, `line_err` becomes 0 and both `pump_up` and `pump_dn` become 0.
- R2: A clock edge with `line_clr` high sets the envelope maximum to 0 and the minimum to 255, and marks the line as having no burst. A sample presented with `burst_gate` in that same cycle is discarded.
- R3: On an edge with `burst_gate` high and `line_clr` low, the maximum takes the sample if the sample is strictly greater, and the minimum takes the sample if it is strictly smaller. Samples taken with `burst_gate` low change neither register.
- R4: The blanking estimate is floor((min + max) / 2), with the sum formed one bit wider than a sample so that it never overflows. For example, min = max = 255 gives 255.
- R5: A line start is an edge where `sync_in` is high and was low at the previous edge. At a line start, `line_err` loads target_height − (blanking − TIP_CODE) as a 10-bit two's-complement value, with TIP_CODE = 4 by default. It uses the envelope as it stood before that edge and otherwise holds its value.
- R6: From a line start until the edge at which `sync_in` is sampled low, `pump_up` is 1 if the latched error exceeds DEAD_BAND, and `pump_dn` is 1 if the error is below −DEAD_BAND (DEAD_BAND = 2 by default). Both are 0 at all other times.
- R7: `pump_up` and `pump_dn` are never high together.
- R8: A line start that sees no gated sample since the last clear or the last line start loads 0 into `line_err` and keeps both pumps low for that sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_sample | input | 8 | Clamped video sample |
| sync_in | input | 1 | High during the sliced sync pulse |
| burst_gate | input | 1 | High while the colour burst is present |
| line_clr | input | 1 | Per-line clear of the envelope registers |
| target_height | input | 8 | Programmed sync height in codes |
| pump_up | output | 1 | Raise enable for the reference charge pump |
| pump_dn | output | 1 | Lower enable for the reference charge pump |
| line_err | output | 10 | Latched signed error of the last measured line |

## Verification
Two collisions matter for this block. The first is a line clear on the same edge as a gated sample. The bench provokes it by raising `burst_gate` with `line_clr` and presenting a value of 200, far above the burst that follows. If that sample survived, it would inflate the midpoint, so the error latched at the next sync shows whether the clear won. The second is a sync rise that ends a line with no burst at all. There the bench expects a zero error and quiet pumps, and a behavioural model compares all three outputs at every clock.

// File: rtl/agc_est_pkg.sv
package agc_est_pkg;

    localparam int SMP_W = 8;
    localparam int ERR_W = SMP_W + 2;

    typedef logic [SMP_W-1:0]        smp_t;
    typedef logic signed [ERR_W-1:0] err_t;

    // running burst envelope of one line
    typedef struct packed {
        smp_t hi;
        smp_t lo;
        logic seen;
    } env_t;

    typedef enum logic [1:0] {
        PUMP_IDLE  = 2'b00,
        PUMP_RAISE = 2'b01,
        PUMP_LOWER = 2'b10
    } pump_cmd_e;

    typedef struct packed {
        err_t      err;
        pump_cmd_e cmd;
    } verdict_t;

    // midpoint with a carry bit so a full-scale pair cannot wrap
    function automatic smp_t env_mid(smp_t a, smp_t b);
        logic [SMP_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[SMP_W:1];
    endfunction

    function automatic err_t widen(smp_t v);
        return $signed({2'b00, v});
    endfunction

endpackage

// File: rtl/burst_peak_tracker.sv
module burst_peak_tracker
    import agc_est_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  smp_t smp,
    input  logic gate,
    input  logic clr,
    input  logic line_start,
    output env_t env
);

    localparam smp_t LO_INIT = '1;
    localparam smp_t HI_INIT = '0;

    env_t env_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            env_q.hi   <= HI_INIT;
            env_q.lo   <= LO_INIT;
            env_q.seen <= 1'b0;
        end else if (gate) begin
            if (smp > env_q.hi) env_q.hi <= smp;
            if (smp < env_q.lo) env_q.lo <= smp;
            env_q.seen <= 1'b1;
        end else if (line_start) begin
            env_q.seen <= 1'b0;
        end
    end

    assign env = env_q;

endmodule

// File: rtl/agc_error_calc.sv
module agc_error_calc
    import agc_est_pkg::*;
#(
    parameter int TIP_CODE  = 4,
    parameter int DEAD_BAND = 2
) (
    input  env_t     env,
    input  smp_t     target,
    output smp_t     blank,
    output verdict_t verdict
);

    localparam err_t TIP_E = err_t'(TIP_CODE);
    localparam err_t DB_P  = err_t'(DEAD_BAND);
    localparam err_t DB_N  = -err_t'(DEAD_BAND);

    err_t height;
    err_t raw_err;

    always_comb begin
        blank   = env_mid(env.lo, env.hi);
        height  = widen(blank) - TIP_E;
        raw_err = widen(target) - height;
        if (!env.seen) begin
            verdict.err = '0;
            verdict.cmd = PUMP_IDLE;
        end else begin
            verdict.err = raw_err;
            if (raw_err > DB_P)
                verdict.cmd = PUMP_RAISE;
            else if (raw_err < DB_N)
                verdict.cmd = PUMP_LOWER;
            else
                verdict.cmd = PUMP_IDLE;
        end
    end

endmodule

// File: rtl/pump_driver.sv
module pump_driver
    import agc_est_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_in,
    input  verdict_t verdict,
    output logic     line_start,
    output err_t     line_err,
    output logic     pump_up,
    output logic     pump_dn
);

    logic      sync_d;
    err_t      err_q;
    pump_cmd_e cmd_q;

    assign line_start = sync_in && !sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= 1'b0;
            err_q  <= '0;
            cmd_q  <= PUMP_IDLE;
        end else begin
            sync_d <= sync_in;
            if (line_start) begin
                err_q <= verdict.err;
                cmd_q <= verdict.cmd;
            end else if (!sync_in) begin
                cmd_q <= PUMP_IDLE;
            end
        end
    end

    assign line_err = err_q;
    assign pump_up  = (cmd_q == PUMP_RAISE);
    assign pump_dn  = (cmd_q == PUMP_LOWER);

endmodule

// File: rtl/burst_agc_err.sv
module burst_agc_err
    import agc_est_pkg::*;
#(
    parameter int TIP_CODE  = 4,
    parameter int DEAD_BAND = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] vid_sample,
    input  logic             sync_in,
    input  logic             burst_gate,
    input  logic             line_clr,
    input  logic [SMP_W-1:0] target_height,
    output logic             pump_up,
    output logic             pump_dn,
    output logic [ERR_W-1:0] line_err
);

    env_t     env_q;
    smp_t     blank;
    verdict_t verdict;
    logic     line_start;
    err_t     err_o;

    burst_peak_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .smp        (vid_sample),
        .gate       (burst_gate),
        .clr        (line_clr),
        .line_start (line_start),
        .env        (env_q)
    );

    agc_error_calc #(
        .TIP_CODE  (TIP_CODE),
        .DEAD_BAND (DEAD_BAND)
    ) u_calc (
        .env     (env_q),
        .target  (target_height),
        .blank   (blank),
        .verdict (verdict)
    );

    pump_driver u_pump (
        .clk        (clk),
        .rst        (rst),
        .sync_in    (sync_in),
        .verdict    (verdict),
        .line_start (line_start),
        .line_err   (err_o),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn)
    );

    assign line_err = err_o;

endmodule

// File: rtl/burst_agc_err_chk.sv
module burst_agc_err_chk
    import agc_est_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sync_in,
    input logic             burst_gate,
    input logic             line_clr,
    input logic             pump_up,
    input logic             pump_dn,
    input logic [ERR_W-1:0] line_err,
    input env_t             env,
    input smp_t             blank
);

    logic prev_sync;
    always_ff @(posedge clk) begin
        if (rst) prev_sync <= 1'b0;
        else     prev_sync <= sync_in;
    end

    // R7
    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn));

    // R6: pumps only follow an edge that saw sync high
    p_pump_sync_r6: assert property (@(posedge clk) disable iff (rst)
        (pump_up || pump_dn) |-> $past(sync_in));

    // R5: error only moves at a line start
    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(sync_in && !prev_sync) |=> $stable(line_err));

    // R2
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        line_clr |=> (env.hi == '0 && env.lo == '1 && !env.seen));

    // R3: outside the gate the envelope is frozen
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!line_clr && !burst_gate) |=> ($stable(env.hi) && $stable(env.lo)));

    // R3: inside the gate the envelope only widens
    p_widen_r3: assert property (@(posedge clk) disable iff (rst)
        (!line_clr && burst_gate) |=> (env.hi >= $past(env.hi) && env.lo <= $past(env.lo)));

    // R4
    p_mid_r4: assert property (@(posedge clk) disable iff (rst)
        env.seen |-> (blank >= env.lo && blank <= env.hi));

    // R8
    p_noburst_r8: assert property (@(posedge clk) disable iff (rst)
        (sync_in && !prev_sync && !env.seen) |=> (line_err == '0 && !pump_up && !pump_dn));

endmodule

bind burst_agc_err burst_agc_err_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .burst_gate (burst_gate),
    .line_clr   (line_clr),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .line_err   (line_err),
    .env        (env_q),
    .blank      (blank)
);

// File: tb/tb_burst_agc_err.sv
`timescale 1ns/1ps
module tb_burst_agc_err;

    localparam int TIP = 4;
    localparam int DB  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        vid_sample = '0;
    logic              sync_in = 1'b0;
    logic              burst_gate = 1'b0;
    logic              line_clr = 1'b0;
    logic [7:0]        target_height = '0;
    logic              pump_up;
    logic              pump_dn;
    logic signed [9:0] line_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_agc_err #(.TIP_CODE(TIP), .DEAD_BAND(DB)) dut (
        .clk(clk), .rst(rst), .vid_sample(vid_sample), .sync_in(sync_in),
        .burst_gate(burst_gate), .line_clr(line_clr), .target_height(target_height),
        .pump_up(pump_up), .pump_dn(pump_dn), .line_err(line_err)
    );

    // behavioural reference model
    int m_hi = 0, m_lo = 255, m_seen = 0, m_prev = 0;
    int m_err = 0, m_up = 0, m_dn = 0;

    always @(posedge clk) begin
        int e;
        int start;
        if (rst) begin
            m_hi = 0; m_lo = 255; m_seen = 0; m_prev = 0;
            m_err = 0; m_up = 0; m_dn = 0;
        end else begin
            start = (sync_in && !m_prev) ? 1 : 0;
            e = 0;
            if (m_seen != 0) e = int'(target_height) - ((m_lo + m_hi) / 2 - TIP);
            if (start != 0) begin
                m_err = e;
                m_up  = (m_seen != 0 && e > DB)  ? 1 : 0;
                m_dn  = (m_seen != 0 && e < -DB) ? 1 : 0;
            end else if (!sync_in) begin
                m_up = 0; m_dn = 0;
            end
            if (line_clr) begin
                m_hi = 0; m_lo = 255; m_seen = 0;
            end else if (burst_gate) begin
                if (int'(vid_sample) > m_hi) m_hi = int'(vid_sample);
                if (int'(vid_sample) < m_lo) m_lo = int'(vid_sample);
                m_seen = 1;
            end else if (start != 0) begin
                m_seen = 0;
            end
            m_prev = sync_in ? 1 : 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 model line_err", int'(line_err), m_err);
            check("R6 model pump_up", int'(pump_up), m_up);
            check("R6 model pump_dn", int'(pump_dn), m_dn);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic burst(input int n, input int v[8], input int clr_smp);
        line_clr   = 1'b1;
        burst_gate = (clr_smp >= 0);
        vid_sample = (clr_smp >= 0) ? 8'(clr_smp) : 8'd33;
        tick();
        line_clr   = 1'b0;
        burst_gate = 1'b0;
        vid_sample = 8'd250;   // outside the gate: must be ignored (R3)
        tick();
        for (int i = 0; i < n; i++) begin
            burst_gate = 1'b1;
            vid_sample = 8'(v[i]);
            tick();
        end
        burst_gate = 1'b0;
        vid_sample = 8'd2;
        repeat (3) tick();
        vid_sample = 8'd254;
        tick();
        vid_sample = 8'd0;
        tick();
    endtask

    task automatic sync_line(input int tgt, input int exp_err, input int exp_up,
                             input int exp_dn, input string req);
        target_height = 8'(tgt);
        sync_in = 1'b1;
        vid_sample = 8'd4;
        tick();
        check({req, " line_err"}, int'(line_err), exp_err);
        check({req, " pump_up"}, int'(pump_up), exp_up);
        check({req, " pump_dn"}, int'(pump_dn), exp_dn);
        check("R7 exclusive", int'(pump_up && pump_dn), 0);
        repeat (3) tick();
        check("R6 held pump_up", int'(pump_up), exp_up);
        check("R6 held pump_dn", int'(pump_dn), exp_dn);
        sync_in = 1'b0;
        tick();
        check("R6 release", int'(pump_up || pump_dn), 0);
        check("R5 err held after sync", int'(line_err), exp_err);
        repeat (2) tick();
    endtask

    initial begin
        int a[8] = '{100, 140, 60, 120, 0, 0, 0, 0};
        repeat (3) tick();
        check("R1 line_err", int'(line_err), 0);
        check("R1 pump_up", int'(pump_up), 0);
        check("R1 pump_dn", int'(pump_dn), 0);
        rst = 1'b0;
        tick();
        sync_line(96, 0, 0, 0, "R8 first line");
        burst(4, a, -1);
        sync_line(96, 0, 0, 0, "R3 envelope 60..140");
        burst(4, a, -1);
        sync_line(100, 4, 1, 0, "R6 raise");
        burst(4, a, -1);
        sync_line(90, -6, 0, 1, "R6 lower");
        burst(4, a, -1);
        sync_line(98, 2, 0, 0, "R6 dead-band top");
        burst(4, a, -1);
        sync_line(94, -2, 0, 0, "R6 dead-band bottom");
        burst(2, '{255, 255, 0, 0, 0, 0, 0, 0}, -1);
        sync_line(0, -251, 0, 1, "R4 full scale");
        burst(2, '{50, 70, 0, 0, 0, 0, 0, 0}, 200);
        sync_line(56, 0, 0, 0, "R2 clear beats gate");
        burst(2, '{1, 2, 0, 0, 0, 0, 0, 0}, -1);
        sync_line(0, 3, 1, 0, "R5 negative height");
        burst(0, '{0, 0, 0, 0, 0, 0, 0, 0}, -1);
        sync_line(50, 0, 0, 0, "R8 empty line");
        rst = 1'b1;
        tick();
        tick();
        check("R1 reset again line_err", int'(line_err), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule